// File: doc/BRIEF.md
# Dual Prescaled Reload Timer

This block provides two independent 16-bit down-counting timer channels behind a small byte-wide processor bus. Each channel owns a live counter and a reload value. It advances on the tick of its own prescaler, which divides the bus clock by two raised to a 4-bit exponent. Both exponents sit in one shared prescale register. A second shared register holds the enable bits, the interrupt-enable bits and the status flags of both channels, plus the action that channel 1 applies to a waveform output pin at each terminal count.

At terminal count a channel reloads, sets its status flag and, if enabled, raises the interrupt line. Software reads a 16-bit counter consistently by taking the high byte first: that read captures the low byte. A status flag is cleared by the two-read sequence described below.

Each channel contains two small state machines.

- **Flag machine.**
  - States: `FLAG_CLEAR`, `FLAG_SET`, `FLAG_ARMED`.
  - Transitions:
    - `CLEAR->SET` on a zero event.
    - `SET->ARMED` on a control-register read.
    - `ARMED->CLEAR` on a read of that channel's counter low byte.
    - `ARMED->SET` on a new zero event. A zero event wins over any read in the same cycle.
- **Read-latch machine.**
  - States: `LAT_LIVE`, `LAT_HELD`.
  - Transitions:
    - `LIVE->HELD` on a counter high-byte read.
    - `HELD->LIVE` on a counter low-byte read.
    - `HELD->HELD` on a further high-byte read, which re-captures the low byte.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, both counters and both reload values read 0xFFFF, the control and prescale registers read 0x00, `wave_out` is 1 and `irq` is 0.
- R2: The byte map is: 0x0 counter-0 low, 0x1 counter-0 high, 0x2 reload-0 low, 0x3 reload-0 high, 0x4 to 0x7 the same for channel 1, 0x8 control, 0x9 prescale. In the prescale register, bits 3:0 set exponent n0 and bits 7:4 set exponent n1.
  - While a channel is enabled, its counter decrements once every 2^n clocks.
  - The prescaler restarts whenever the channel is disabled.
  - The first tick falls on the 2^n-th clock edge after the edge that wrote the enable bit.
- R3: A tick that finds the counter at 1 or 0 loads the reload value instead of decrementing. It also sets that channel's status flag (a zero event).
- R4: Counter byte writes take effect only while that channel's enable bit is 0. While the channel is enabled, such a write is ignored and the counter keeps its value. Reload byte writes are always accepted.
- R5: Reading a counter high byte captures the current low byte. The next low-byte read of that channel returns the captured byte. A low-byte read with no pending capture returns the live low byte.
- R6: A status flag clears only when a control read made while the flag is set is followed by a low-byte read of that channel's counter. A low-byte read without that earlier control read leaves the flag set.
- R7: `irq` is 1 exactly when some channel has both its status flag and its interrupt-enable bit set.
- R8: On a channel-1 zero event, control bits 5:4 act on `wave_out`: 00 hold, 01 toggle, 10 force 0, 11 force 1. Channel-0 events never change `wave_out`.
- R9: Control bits are: bit 0 enable-0, bit 1 enable-1, bit 2 irq-enable-0, bit 3 irq-enable-1, bits 5:4 wave action, bit 6 flag-0, bit 7 flag-1. Bits 7:6 are read-only, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Bus select, qualifies read and write strobes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; its side effects occur at the clock edge |
| bus_addr | input | 4 | Byte register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |
| wave_out | output | 1 | Channel-1 waveform output |

## Verification
The bench targets the following corner cases:

- **Tick timing.** It checks the exact cycle of the first prescaled tick after enabling, and the 1-or-0 terminal condition. An off-by-one prescaler or reload would leave the counter one count away from the expected value.
- **Coherent read.** It reads the high byte and then the low byte while the counter runs, and checks that the low byte is the captured one rather than the live one. It also checks that the capture is used only once.
- **Flag clear ordering.** It reads the low byte before and after a control read. A design that cleared on any low-byte read would drop `irq` too early.
- **Waveform actions.** It walks all four wave actions with a short reload. A wrong decode of bits 5:4 would show as a toggle where a hold was asked for.
- **Ignored writes.** It checks that counter writes are dropped while the channel is enabled.

// File: rtl/drt_pkg.sv
package drt_pkg;

    typedef enum logic [1:0] {
        FLAG_CLEAR = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_ARMED = 2'd2
    } flag_state_t;

    typedef enum logic {
        LAT_LIVE = 1'b0,
        LAT_HELD = 1'b1
    } latch_state_t;

    typedef enum logic [1:0] {
        WAVE_HOLD   = 2'b00,
        WAVE_TOGGLE = 2'b01,
        WAVE_LOW    = 2'b10,
        WAVE_HIGH   = 2'b11
    } wave_mode_t;

    localparam int          ADDR_W     = 4;
    localparam logic [3:0]  ADDR_CTRL  = 4'h8;
    localparam logic [3:0]  ADDR_PRESC = 4'h9;

endpackage

// File: rtl/drt_prescaler.sv
module drt_prescaler #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             tick
);
    localparam int DIV_W = (1 << EXP_W) - 1;

    logic [DIV_W-1:0] pc_q;
    logic [DIV_W-1:0] mask;

    assign mask = ~({DIV_W{1'b1}} << exp_sel);
    assign tick = run && ((pc_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pc_q <= '0;
        else if (!run) pc_q <= '0;
        else           pc_q <= pc_q + 1'b1;
    end

endmodule

// File: rtl/drt_channel.sv
module drt_channel
    import drt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] exp_sel,
    input  logic             wr_cnt_lo,
    input  logic             wr_cnt_hi,
    input  logic             wr_rl_lo,
    input  logic             wr_rl_hi,
    input  logic [7:0]       wdata,
    input  logic             rd_ctrl,
    input  logic             rd_cnt_lo,
    input  logic             rd_cnt_hi,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] rl_q,
    output logic [7:0]       lo_view,
    output logic             flag,
    output logic             zero_evt
);
    localparam int HI_W = CNT_W - 8;

    logic         tick;
    flag_state_t  flag_st, flag_nx;
    latch_state_t lat_st, lat_nx;
    logic [7:0]   lat_q;

    drt_prescaler #(.EXP_W(EXP_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .exp_sel (exp_sel),
        .tick    (tick)
    );

    assign zero_evt = tick && (cnt_q <= CNT_W'(1));

    // live counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '1;
        else if (zero_evt)          cnt_q <= rl_q;
        else if (tick)              cnt_q <= cnt_q - 1'b1;
        else if (!run && wr_cnt_lo) cnt_q[7:0] <= wdata;
        else if (!run && wr_cnt_hi) cnt_q[CNT_W-1:8] <= wdata[HI_W-1:0];
    end

    // reload value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rl_q <= '1;
        else if (wr_rl_lo) rl_q[7:0] <= wdata;
        else if (wr_rl_hi) rl_q[CNT_W-1:8] <= wdata[HI_W-1:0];
    end

    // flag machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_st <= FLAG_CLEAR;
        else        flag_st <= flag_nx;
    end

    // flag machine: next state
    always_comb begin
        flag_nx = flag_st;
        unique case (flag_st)
            FLAG_CLEAR: if (zero_evt)       flag_nx = FLAG_SET;
            FLAG_SET:   if (zero_evt)       flag_nx = FLAG_SET;
                        else if (rd_ctrl)   flag_nx = FLAG_ARMED;
            FLAG_ARMED: if (zero_evt)       flag_nx = FLAG_SET;
                        else if (rd_cnt_lo) flag_nx = FLAG_CLEAR;
            default:                        flag_nx = FLAG_CLEAR;
        endcase
    end

    assign flag = (flag_st != FLAG_CLEAR);

    // read-latch machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_st <= LAT_LIVE;
            lat_q  <= '0;
        end else begin
            lat_st <= lat_nx;
            if (rd_cnt_hi) lat_q <= cnt_q[7:0];
        end
    end

    always_comb begin
        lat_nx = lat_st;
        unique case (lat_st)
            LAT_LIVE: if (rd_cnt_hi) lat_nx = LAT_HELD;
            LAT_HELD: if (rd_cnt_lo) lat_nx = LAT_LIVE;
            default:                 lat_nx = LAT_LIVE;
        endcase
    end

    assign lo_view = (lat_st == LAT_HELD) ? lat_q : cnt_q[7:0];

    p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - 1'b1);

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> (cnt_q == $past(rl_q)) && flag);

    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt_q));

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt_hi |=> lo_view == $past(cnt_q[7:0]));

endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import drt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int EXP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              wave_out
);
    localparam int NUM_CH = 2;

    logic wr_stb, rd_stb;
    assign wr_stb = bus_cs && bus_wr;
    assign rd_stb = bus_cs && bus_rd;

    logic [NUM_CH-1:0]            run_q, ie_q, flag, evt;
    wave_mode_t                   mode_q;
    logic [NUM_CH-1:0][EXP_W-1:0] exp_q;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_arr, rl_arr;
    logic [NUM_CH-1:0][7:0]       lo_arr;

    // shared control and prescale registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            ie_q   <= '0;
            mode_q <= WAVE_HOLD;
            exp_q  <= '0;
        end else if (wr_stb && bus_addr == ADDR_CTRL) begin
            run_q  <= bus_wdata[1:0];
            ie_q   <= bus_wdata[3:2];
            mode_q <= wave_mode_t'(bus_wdata[5:4]);
        end else if (wr_stb && bus_addr == ADDR_PRESC) begin
            exp_q  <= bus_wdata[NUM_CH*EXP_W-1:0];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(c * 4);
        drt_channel #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run_q[c]),
            .exp_sel   (exp_q[c]),
            .wr_cnt_lo (wr_stb && bus_addr == BASE),
            .wr_cnt_hi (wr_stb && bus_addr == BASE + 4'd1),
            .wr_rl_lo  (wr_stb && bus_addr == BASE + 4'd2),
            .wr_rl_hi  (wr_stb && bus_addr == BASE + 4'd3),
            .wdata     (bus_wdata),
            .rd_ctrl   (rd_stb && bus_addr == ADDR_CTRL),
            .rd_cnt_lo (rd_stb && bus_addr == BASE),
            .rd_cnt_hi (rd_stb && bus_addr == BASE + 4'd1),
            .cnt_q     (cnt_arr[c]),
            .rl_q      (rl_arr[c]),
            .lo_view   (lo_arr[c]),
            .flag      (flag[c]),
            .zero_evt  (evt[c])
        );
    end

    // read data
    always_comb begin
        bus_rdata = '0;
        if (!bus_addr[3]) begin
            unique case (bus_addr[1:0])
                2'd0: bus_rdata = lo_arr[bus_addr[2]];
                2'd1: bus_rdata = cnt_arr[bus_addr[2]][CNT_W-1:CNT_W-8];
                2'd2: bus_rdata = rl_arr[bus_addr[2]][7:0];
                2'd3: bus_rdata = rl_arr[bus_addr[2]][CNT_W-1:CNT_W-8];
                default: bus_rdata = '0;
            endcase
        end else if (bus_addr == ADDR_CTRL) begin
            bus_rdata = {flag, mode_q, ie_q, run_q};
        end else if (bus_addr == ADDR_PRESC) begin
            bus_rdata = exp_q;
        end
    end

    // waveform output driven by channel 1 only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave_out <= 1'b1;
        end else if (evt[1]) begin
            unique case (mode_q)
                WAVE_HOLD:   wave_out <= wave_out;
                WAVE_TOGGLE: wave_out <= ~wave_out;
                WAVE_LOW:    wave_out <= 1'b0;
                WAVE_HIGH:   wave_out <= 1'b1;
                default:     wave_out <= wave_out;
            endcase
        end
    end

    assign irq = |(flag & ie_q);

    p_wave_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[1] && mode_q == WAVE_LOW) |=> !wave_out);

    p_wave_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[1] && mode_q == WAVE_HIGH) |=> wave_out);

    p_wave_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[1] && mode_q == WAVE_TOGGLE) |=> wave_out != $past(wave_out));

    p_wave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !evt[1] |=> $stable(wave_out));

endmodule

// File: tb/dual_reload_timer_tb_top.sv
`timescale 1ns/1ps
module dual_reload_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, wave_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    dual_reload_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .wave_out(wave_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cnt[2], m_rl[2], m_pc[2], m_exp[2], m_lat[2];
    bit m_en[2], m_ie[2], m_flag[2], m_arm[2], m_latv[2];
    int m_mode;
    bit m_wave;

    function automatic int m_read(input int a);
        int ch;
        ch = (a >> 2) & 1;
        if (a < 8) begin
            case (a & 3)
                0: return m_latv[ch] ? m_lat[ch] : (m_cnt[ch] & 8'hFF);
                1: return (m_cnt[ch] >> 8) & 8'hFF;
                2: return m_rl[ch] & 8'hFF;
                default: return (m_rl[ch] >> 8) & 8'hFF;
            endcase
        end
        if (a == 8)
            return (int'(m_flag[1]) << 7) | (int'(m_flag[0]) << 6) | (m_mode << 4) |
                   (int'(m_ie[1]) << 3) | (int'(m_ie[0]) << 2) |
                   (int'(m_en[1]) << 1) | int'(m_en[0]);
        if (a == 9) return (m_exp[1] << 4) | m_exp[0];
        return 0;
    endfunction

    always @(posedge clk) begin
        int a, wd, div, base, ncnt;
        bit rd, wr, tick;
        bit evt[2];
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_cnt[c] = 16'hFFFF; m_rl[c] = 16'hFFFF; m_pc[c] = 0; m_exp[c] = 0;
                m_lat[c] = 0; m_en[c] = 0; m_ie[c] = 0; m_flag[c] = 0;
                m_arm[c] = 0; m_latv[c] = 0;
            end
            m_mode = 0; m_wave = 1;
        end else begin
            rd = bus_cs && bus_rd; wr = bus_cs && bus_wr;
            a = int'(bus_addr); wd = int'(bus_wdata);
            for (int c = 0; c < 2; c++) begin
                base = c * 4;
                div  = 1 << m_exp[c];
                tick = m_en[c] && ((m_pc[c] % div) == div - 1);
                evt[c] = tick && (m_cnt[c] <= 1);
                ncnt = m_cnt[c];
                if (evt[c]) ncnt = m_rl[c];
                else if (tick) ncnt = m_cnt[c] - 1;
                else if (!m_en[c] && wr && a == base) ncnt = (m_cnt[c] & 16'hFF00) | wd;
                else if (!m_en[c] && wr && a == base + 1) ncnt = (m_cnt[c] & 16'h00FF) | (wd << 8);
                if (wr && a == base + 2) m_rl[c] = (m_rl[c] & 16'hFF00) | wd;
                if (wr && a == base + 3) m_rl[c] = (m_rl[c] & 16'h00FF) | (wd << 8);
                if (evt[c]) begin m_flag[c] = 1; m_arm[c] = 0; end
                else if (rd && a == 8 && m_flag[c]) m_arm[c] = 1;
                else if (rd && a == base && m_arm[c]) begin m_flag[c] = 0; m_arm[c] = 0; end
                if (rd && a == base + 1) begin m_lat[c] = m_cnt[c] & 8'hFF; m_latv[c] = 1; end
                else if (rd && a == base) m_latv[c] = 0;
                m_pc[c]  = m_en[c] ? (m_pc[c] + 1) % 32768 : 0;
                m_cnt[c] = ncnt;
            end
            if (evt[1]) begin
                case (m_mode)
                    1: m_wave = !m_wave;
                    2: m_wave = 0;
                    3: m_wave = 1;
                    default: ;
                endcase
            end
            if (wr && a == 8) begin
                m_en[0] = wd[0]; m_en[1] = wd[1]; m_ie[0] = wd[2]; m_ie[1] = wd[3];
                m_mode = (wd >> 4) & 3;
            end
            if (wr && a == 9) begin m_exp[0] = wd & 15; m_exp[1] = (wd >> 4) & 15; end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            check("R7 irq vs model", int'(irq),
                  int'((m_flag[0] && m_ie[0]) || (m_flag[1] && m_ie[1])));
            check("R8 wave_out vs model", int'(wave_out), int'(m_wave));
            check("R9 bus_rdata vs model", int'(bus_rdata), m_read(int'(bus_addr)));
        end
    end

    // ---------------- bus tasks (called at a falling edge) ----------------
    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        bus_cs = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_cs = 0; bus_rd = 0;
    endtask

    task automatic read_check(input logic [3:0] a, input int exp, input string tag);
        logic [7:0] d;
        bus_read(a, d);
        check(tag, int'(d), exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 wave_out reset", int'(wave_out), 1);
        check("R1 irq reset", int'(irq), 0);
        for (int a = 0; a < 8; a++) read_check(4'(a), 8'hFF, "R1 counter/reload reset");
        read_check(4'h8, 8'h00, "R1 control reset");
        read_check(4'h9, 8'h00, "R1 prescale reset");

        // R2 prescaled count on channel 1, exponent 2
        bus_write(4'h9, 8'h20);
        bus_write(4'h4, 8'h10);
        bus_write(4'h5, 8'h00);
        bus_write(4'h8, 8'h02);
        repeat (8) @(posedge clk);
        @(negedge clk);
        bus_write(4'h8, 8'h00);
        read_check(4'h5, 8'h00, "R2 ch1 high after 9 edges");
        read_check(4'h4, 8'h0E, "R2 ch1 low after two ticks");

        // R3 terminal count and reload on channel 0, R7 irq
        bus_write(4'h0, 8'h02);
        bus_write(4'h1, 8'h00);
        bus_write(4'h2, 8'h03);
        bus_write(4'h3, 8'h00);
        bus_write(4'h8, 8'h05);
        @(posedge clk); #1;
        check("R7 irq before zero event", int'(irq), 0);
        @(posedge clk); #1;
        check("R3 R7 irq after zero event", int'(irq), 1);
        @(negedge clk);
        bus_write(4'h8, 8'h04);
        read_check(4'h1, 8'h00, "R3 ch0 high after reload");
        read_check(4'h0, 8'h02, "R3 ch0 low reloaded then decremented");

        // R6 flag clear ordering
        read_check(4'h0, 8'h02, "R6 low read without control read");
        check("R6 flag kept after lone low read", int'(irq), 1);
        read_check(4'h8, 8'h44, "R6 R9 control shows flag0 and ie0");
        check("R6 flag kept after control read", int'(irq), 1);
        read_check(4'h0, 8'h02, "R6 low read after control read");
        check("R6 irq after clear", int'(irq), 0);
        read_check(4'h8, 8'h04, "R6 flag0 cleared");

        // R9 read-only flag bits, prescale read-back
        bus_write(4'h8, 8'hC0);
        read_check(4'h8, 8'h00, "R9 flag bits not writable");
        bus_write(4'h9, 8'hA5);
        read_check(4'h9, 8'hA5, "R9 prescale read-back");

        // R4 counter writes ignored while enabled
        bus_write(4'h9, 8'h0F);
        bus_write(4'h8, 8'h01);
        bus_write(4'h0, 8'h55);
        bus_write(4'h2, 8'h77);
        read_check(4'h1, 8'h00, "R4 high unchanged while enabled");
        read_check(4'h0, 8'h02, "R4 write ignored while enabled");
        read_check(4'h2, 8'h77, "R4 reload write accepted while enabled");
        bus_write(4'h8, 8'h00);
        bus_write(4'h0, 8'h55);
        read_check(4'h1, 8'h00, "R4 high after disabled write");
        read_check(4'h0, 8'h55, "R4 write accepted while disabled");

        // R5 coherent read while counting
        bus_write(4'h9, 8'h00);
        bus_write(4'h0, 8'h00);
        bus_write(4'h1, 8'h01);
        bus_write(4'h2, 8'hFF);
        bus_write(4'h3, 8'hFF);
        bus_write(4'h8, 8'h01);
        read_check(4'h1, 8'h01, "R5 high byte 0x0100");
        read_check(4'h0, 8'h00, "R5 low returns captured byte");
        read_check(4'h0, 8'hFE, "R5 second low returns live byte");
        bus_write(4'h8, 8'h00);

        // R8 waveform actions on channel 1, R7 irq enable gating
        bus_write(4'h4, 8'h01);
        bus_write(4'h5, 8'h00);
        bus_write(4'h6, 8'h02);
        bus_write(4'h7, 8'h00);
        bus_write(4'h8, 8'h12);
        @(posedge clk); #1;
        check("R8 toggle first event", int'(wave_out), 0);
        @(posedge clk); @(posedge clk); #1;
        check("R8 toggle second event", int'(wave_out), 1);
        check("R7 irq masked by ie1=0", int'(irq), 0);
        @(negedge clk);
        bus_write(4'h8, 8'h22);
        repeat (4) @(posedge clk); #1;
        check("R8 force low", int'(wave_out), 0);
        @(negedge clk);
        bus_write(4'h8, 8'h32);
        repeat (4) @(posedge clk); #1;
        check("R8 force high", int'(wave_out), 1);
        @(negedge clk);
        bus_write(4'h8, 8'h02);
        repeat (6) @(posedge clk); #1;
        check("R8 hold over three events", int'(wave_out), 1);
        @(negedge clk);
        bus_write(4'h8, 8'h0A);
        check("R7 irq with ie1 set", int'(irq), 1);
        bus_write(4'h8, 8'h00);

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule